// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the control side of an SDRAM device model or controller shadow. On every rising clock edge it samples clock enable, chip select, the three active-low strobes, the bank-select bits, the address bus and the per-lane data masks. It turns them into a decoded command and keeps a live view of which of the four banks hold an open row and which row that is. It also captures column, auto-precharge and mode opcode fields, and runs the burst counter.

When clock enable is sampled low, the block classifies the resulting low-power state from the bank and burst status it already holds, and it freezes its pipelines. A mask path reports, per byte lane, which write beats must be dropped in the same cycle and which read lanes must float two clocks after the mask was sampled. A one-cycle error pulse marks commands that are illegal for the current bank state.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset (rst_n low) all banks are idle, no burst runs, the power state is 0 (running), and cmd_vld_o, err_o, wr_mask_o and rd_hiz_o are all zero.
- R2: An edge with cs_n high and cke high decodes nothing: cmd_vld_o is 0 afterwards and no bank changes state.
- R3: The command code is {ras_n, cas_n, we_n}: 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 AUTO REFRESH, 000 LOAD MODE, 110 BURST TERMINATE, 111 NOP. ACTIVE to an idle bank opens bank ba and stores addr[11:0] in rows_o[ba*12 +: 12].
- R4: READ or WRITE to an open bank sets col_o to addr[9:0], auto_pre_o to addr[10] and rw_bank_o to ba, and starts a burst: burst_active_o is high for BURST_LEN cycles while burst_cnt_o shows 0 to BURST_LEN-1, one step per edge; burst_wr_o is 1 for a write.
- R5: A burst started with addr[10] high closes its bank on the edge that ends the burst; without it the bank stays open. BURST TERMINATE ends the burst at once and leaves the bank open.
- R6: PRECHARGE with addr[10] high closes every bank; with addr[10] low it closes only bank ba.
- R7: On a write-beat edge wr_mask_o shows the dqm value sampled at that same edge; on any other edge it is zero.
- R8: A dqm lane sampled high on a read-beat edge k is high on rd_hiz_o after edge k+1 and not after edge k.
- R9: READ or WRITE to an idle bank, and ACTIVE to an open bank, raise err_o for one cycle and change neither bank state nor burst state.
- R10: An edge with cke low decodes no command; pwr_state_o becomes 3 (clock suspend) if a burst is running, else 2 (active power-down) if any bank is open, else 1 (precharge power-down or self refresh); an edge with cke high sets it to 0.
- R11: While cke is low, burst_cnt_o and rd_hiz_o hold their values; the first edge with cke high resumes counting and the read-mask pipeline.
- R12: LOAD MODE captures addr into mode_o; every decoded command appears on cmd_o with cmd_vld_o high after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Row, column, precharge-all or opcode field |
| dqm | input | DQM_W | Per-lane data mask |
| cmd_o | output | 3 | Last decoded command code |
| cmd_vld_o | output | 1 | A command was decoded on the last edge |
| bank_open_o | output | 2**BA_W | One bit per bank, high when a row is open |
| rows_o | output | 2**BA_W*ADDR_W | Open row per bank, bank b in slice b |
| col_o | output | COL_W | Column of the last accepted READ or WRITE |
| auto_pre_o | output | 1 | Auto-precharge flag of that access |
| rw_bank_o | output | BA_W | Bank of that access |
| mode_o | output | ADDR_W | Last mode opcode |
| burst_active_o | output | 1 | A burst is in progress |
| burst_wr_o | output | 1 | The burst is a write |
| burst_cnt_o | output | $clog2(BURST_LEN) | Beat index of the burst |
| pwr_state_o | output | 2 | 0 running, 1 precharge power-down, 2 active power-down, 3 clock suspend |
| wr_mask_o | output | DQM_W | Lanes dropped for the write beat of the last edge |
| rd_hiz_o | output | DQM_W | Read lanes held in high impedance |
| err_o | output | 1 | Illegal command pulse |

## Verification
The bench builds the block with BURST_LEN = 4 and DQM_W = 4, leaving the four-bank, 12-bit address defaults. A four-beat burst keeps the end-of-burst edge, the auto-precharge close and a clock-suspend gap that freezes the counter mid-burst all inside a few cycles, and four lanes let distinct mask patterns on successive beats show that each beat's mask lands on its own cycle and the read path lags by exactly two clocks.

// File: rtl/sdram_cmd_pkg.sv
// Shared command and power-state encodings for the SDRAM command tracker.
// Assumes the active-low strobe truth table {ras_n, cas_n, we_n}.
package sdram_cmd_pkg;
    typedef enum logic [2:0] {
        CMD_LMR = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_BST = 3'b110,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [1:0] {
        PS_RUN     = 2'd0,
        PS_PRE_PD  = 2'd1,
        PS_ACT_PD  = 2'd2,
        PS_SUSPEND = 2'd3
    } pwr_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
// Combinational command decoder. A command is valid only when clock enable
// is high and chip select is low; otherwise nothing is decoded.
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd,
    output logic valid
);
    // Map strobes to the command code and qualify with select and enable
    always_comb begin
        cmd   = cmd_e'({ras_n, cas_n, we_n});
        valid = cke & ~cs_n;
    end
endmodule

// File: rtl/sdram_bank_track.sv
// Per-bank open/idle state and row storage, plus the illegal-command flag.
// Assumes close requests from the burst controller target a single bank.
module sdram_bank_track
    import sdram_cmd_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 12,
    localparam int NBANK = 1 << BA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid,
    input  cmd_e                   cmd,
    input  logic [BA_W-1:0]        ba,
    input  logic [ROW_W-1:0]       row,
    input  logic                   all_sel,
    input  logic                   close_req,
    input  logic [BA_W-1:0]        close_bank,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] rows,
    output logic                   sel_open,
    output logic                   err
);
    assign sel_open = bank_open[ba];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Open, close and row capture for one bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[b]               <= 1'b0;
                rows[b*ROW_W +: ROW_W]     <= '0;
            end else if (valid && cmd == CMD_PRE && (all_sel || ba == BA_W'(b))) begin
                bank_open[b] <= 1'b0;
            end else if (close_req && close_bank == BA_W'(b)) begin
                bank_open[b] <= 1'b0;
            end else if (valid && cmd == CMD_ACT && ba == BA_W'(b) && !bank_open[b]) begin
                bank_open[b]           <= 1'b1;
                rows[b*ROW_W +: ROW_W] <= row;
            end
        end
    end

    // One-cycle pulse for access to an idle bank or activate of an open one
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= valid && (((cmd == CMD_RD || cmd == CMD_WR) && !sel_open)
                                     || (cmd == CMD_ACT && sel_open));
    end
endmodule

// File: rtl/sdram_burst_ctl.sv
// Burst counter. Starts on an accepted READ/WRITE, steps once per enabled
// edge, freezes while clock enable is low and requests an auto-precharge
// close on the edge that ends the burst. Assumes BURST_LEN >= 2.
module sdram_burst_ctl #(
    parameter int BURST_LEN = 4,
    parameter int BA_W      = 2,
    localparam int CNT_W    = $clog2(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic             start_wr,
    input  logic             start_ap,
    input  logic [BA_W-1:0]  start_bank,
    input  logic             stop,
    output logic             active,
    output logic             is_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             wr_beat,
    output logic             rd_beat,
    output logic             close_req,
    output logic [BA_W-1:0]  close_bank
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

    logic ap_q;
    logic beat_cont;

    // Beat and close qualification for the current edge
    always_comb begin
        beat_cont  = cke && active && (cnt != LAST) && !stop;
        wr_beat    = (start && start_wr) || (beat_cont && is_wr && !start);
        rd_beat    = (start && !start_wr) || (beat_cont && !is_wr && !start);
        close_req  = cke && active && (cnt == LAST) && ap_q && !start && !stop;
    end

    // Burst state: start, terminate, step or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            is_wr      <= 1'b0;
            ap_q       <= 1'b0;
            cnt        <= '0;
            close_bank <= '0;
        end else if (cke) begin
            if (start) begin
                active     <= 1'b1;
                is_wr      <= start_wr;
                ap_q       <= start_ap;
                cnt        <= '0;
                close_bank <= start_bank;
            end else if (stop || (active && cnt == LAST)) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (active) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdram_dqm_pipe.sv
// Data-mask paths: write mask registered on the beat edge, read mask
// delayed through two stages. Both read stages hold while clock enable is low.
module sdram_dqm_pipe #(
    parameter int DQM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             wr_beat,
    input  logic             rd_beat,
    input  logic [DQM_W-1:0] dqm,
    output logic [DQM_W-1:0] wr_mask,
    output logic [DQM_W-1:0] rd_hiz
);
    logic [DQM_W-1:0] rd_s1;

    // Capture masks for write beats and shift the read-mask pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_mask <= '0;
            rd_s1   <= '0;
            rd_hiz  <= '0;
        end else if (cke) begin
            wr_mask <= wr_beat ? dqm : '0;
            rd_s1   <= rd_beat ? dqm : '0;
            rd_hiz  <= rd_s1;
        end else begin
            wr_mask <= '0;
        end
    end
endmodule

// File: rtl/sdram_cmd_tracker.sv
// Top: decodes sampled SDRAM control inputs, tracks four banks, runs the
// burst counter, the mask pipeline and the low-power classification.
// Assumes a single rank and a fixed burst length.
module sdram_cmd_tracker
    import sdram_cmd_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int ADDR_W    = 12,
    parameter int COL_W     = 10,
    parameter int AP_BIT    = 10,
    parameter int DQM_W     = 8,
    parameter int BURST_LEN = 4,
    localparam int NBANK    = 1 << BA_W,
    localparam int CNT_W    = $clog2(BURST_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke,
    input  logic                    cs_n,
    input  logic                    ras_n,
    input  logic                    cas_n,
    input  logic                    we_n,
    input  logic [BA_W-1:0]         ba,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DQM_W-1:0]        dqm,
    output logic [2:0]              cmd_o,
    output logic                    cmd_vld_o,
    output logic [NBANK-1:0]        bank_open_o,
    output logic [NBANK*ADDR_W-1:0] rows_o,
    output logic [COL_W-1:0]        col_o,
    output logic                    auto_pre_o,
    output logic [BA_W-1:0]         rw_bank_o,
    output logic [ADDR_W-1:0]       mode_o,
    output logic                    burst_active_o,
    output logic                    burst_wr_o,
    output logic [CNT_W-1:0]        burst_cnt_o,
    output logic [1:0]              pwr_state_o,
    output logic [DQM_W-1:0]        wr_mask_o,
    output logic [DQM_W-1:0]        rd_hiz_o,
    output logic                    err_o
);
    cmd_e            cmd;
    logic            valid;
    logic            sel_open;
    logic            start;
    logic            wr_beat;
    logic            rd_beat;
    logic            close_req;
    logic [BA_W-1:0] close_bank;

    sdram_cmd_decode u_dec (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cmd(cmd), .valid(valid)
    );

    sdram_bank_track #(.BA_W(BA_W), .ROW_W(ADDR_W)) u_banks (
        .clk(clk), .rst_n(rst_n), .valid(valid), .cmd(cmd), .ba(ba),
        .row(addr), .all_sel(addr[AP_BIT]), .close_req(close_req),
        .close_bank(close_bank), .bank_open(bank_open_o), .rows(rows_o),
        .sel_open(sel_open), .err(err_o)
    );

    assign start = valid && (cmd == CMD_RD || cmd == CMD_WR) && sel_open;

    sdram_burst_ctl #(.BURST_LEN(BURST_LEN), .BA_W(BA_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start),
        .start_wr(cmd == CMD_WR), .start_ap(addr[AP_BIT]), .start_bank(ba),
        .stop(valid && cmd == CMD_BST), .active(burst_active_o),
        .is_wr(burst_wr_o), .cnt(burst_cnt_o), .wr_beat(wr_beat),
        .rd_beat(rd_beat), .close_req(close_req), .close_bank(close_bank)
    );

    sdram_dqm_pipe #(.DQM_W(DQM_W)) u_dqm (
        .clk(clk), .rst_n(rst_n), .cke(cke), .wr_beat(wr_beat),
        .rd_beat(rd_beat), .dqm(dqm), .wr_mask(wr_mask_o), .rd_hiz(rd_hiz_o)
    );

    // Report the decoded command and capture access and mode fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o      <= 3'b111;
            cmd_vld_o  <= 1'b0;
            col_o      <= '0;
            auto_pre_o <= 1'b0;
            rw_bank_o  <= '0;
            mode_o     <= '0;
        end else begin
            cmd_vld_o <= valid;
            if (valid) cmd_o <= cmd;
            if (start) begin
                col_o      <= addr[COL_W-1:0];
                auto_pre_o <= addr[AP_BIT];
                rw_bank_o  <= ba;
            end
            if (valid && cmd == CMD_LMR) mode_o <= addr;
        end
    end

    // Classify the low-power state from burst and bank status
    always_ff @(posedge clk) begin
        if (!rst_n)              pwr_state_o <= PS_RUN;
        else if (cke)            pwr_state_o <= PS_RUN;
        else if (burst_active_o) pwr_state_o <= PS_SUSPEND;
        else if (|bank_open_o)   pwr_state_o <= PS_ACT_PD;
        else                     pwr_state_o <= PS_PRE_PD;
    end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
// Assertion checker for sdram_cmd_tracker, attached by bind below.
module sdram_cmd_tracker_chk #(
    parameter int BA_W   = 2,
    parameter int DQM_W  = 8,
    parameter int CNT_W  = 2,
    localparam int NBANK = 1 << BA_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             cs_n,
    input logic [2:0]       code,
    input logic [BA_W-1:0]  ba,
    input logic             a10,
    input logic [DQM_W-1:0] dqm,
    input logic [NBANK-1:0] bank_open_o,
    input logic             burst_active_o,
    input logic [CNT_W-1:0] burst_cnt_o,
    input logic [1:0]       pwr_state_o,
    input logic [DQM_W-1:0] wr_mask_o,
    input logic [DQM_W-1:0] rd_hiz_o,
    input logic             err_o
);
    AST_DESELECT_NO_BANK_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !burst_active_o) |=> $stable(bank_open_o)); // R2

    AST_PRECHARGE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && code == 3'b010 && a10) |=> (bank_open_o == '0)); // R6

    AST_WRITE_MASK_SAME_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && code == 3'b100 && bank_open_o[ba]) |=> (wr_mask_o == $past(dqm))); // R7

    AST_DOUBLE_ACTIVATE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && code == 3'b011 && bank_open_o[ba]) |=> err_o); // R9

    AST_SUSPEND_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && burst_active_o) |=> (pwr_state_o == 2'd3)); // R10

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(burst_cnt_o) && $stable(rd_hiz_o))); // R11
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .BA_W(BA_W), .DQM_W(DQM_W), .CNT_W(CNT_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
    .code({ras_n, cas_n, we_n}), .ba(ba), .a10(addr[AP_BIT]), .dqm(dqm),
    .bank_open_o(bank_open_o), .burst_active_o(burst_active_o),
    .burst_cnt_o(burst_cnt_o), .pwr_state_o(pwr_state_o),
    .wr_mask_o(wr_mask_o), .rd_hiz_o(rd_hiz_o), .err_o(err_o)
);

// File: tb/test_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module test_sdram_cmd_tracker;
    localparam int DQM_W = 4;
    localparam int BL    = 4;

    localparam logic [2:0] C_LMR = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                           C_ACT = 3'b011, C_WR  = 3'b100, C_RD  = 3'b101,
                           C_BST = 3'b110, C_NOP = 3'b111;

    logic clk = 1'b0;
    logic rst_n, cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [DQM_W-1:0] dqm;
    logic [2:0]  cmd_o;
    logic        cmd_vld_o;
    logic [3:0]  bank_open_o;
    logic [47:0] rows_o;
    logic [9:0]  col_o;
    logic        auto_pre_o;
    logic [1:0]  rw_bank_o;
    logic [11:0] mode_o;
    logic        burst_active_o, burst_wr_o;
    logic [1:0]  burst_cnt_o;
    logic [1:0]  pwr_state_o;
    logic [DQM_W-1:0] wr_mask_o, rd_hiz_o;
    logic        err_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdram_cmd_tracker #(.DQM_W(DQM_W), .BURST_LEN(BL)) i_sdram_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
        .cmd_o(cmd_o), .cmd_vld_o(cmd_vld_o), .bank_open_o(bank_open_o),
        .rows_o(rows_o), .col_o(col_o), .auto_pre_o(auto_pre_o),
        .rw_bank_o(rw_bank_o), .mode_o(mode_o),
        .burst_active_o(burst_active_o), .burst_wr_o(burst_wr_o),
        .burst_cnt_o(burst_cnt_o), .pwr_state_o(pwr_state_o),
        .wr_mask_o(wr_mask_o), .rd_hiz_o(rd_hiz_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs at the falling edge, return just after the rising edge
    task automatic issue(input logic k, input logic cs, input logic [2:0] c,
                         input logic [1:0] b, input logic [11:0] a,
                         input logic [DQM_W-1:0] m);
        @(negedge clk);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a; dqm = m;
        @(posedge clk);
        #1;
    endtask

    task automatic nop(input logic [DQM_W-1:0] m);
        issue(1'b1, 1'b0, C_NOP, 2'd0, 12'h000, m);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP;
        ba = '0; addr = '0; dqm = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 banks", bank_open_o, 0);
        chk("R1 burst", burst_active_o, 0);
        chk("R1 pwr", pwr_state_o, 0);
        chk("R1 vld/err", {cmd_vld_o, err_o}, 0);
        chk("R1 masks", {wr_mask_o, rd_hiz_o}, 0);
    endtask

    task automatic t_deselect();
        do_reset();
        issue(1'b1, 1'b1, C_ACT, 2'd0, 12'h123, 0);
        chk("R2 no open", bank_open_o, 0);
        chk("R2 no vld", cmd_vld_o, 0);
    endtask

    task automatic t_activate();
        do_reset();
        issue(1'b1, 1'b0, C_ACT, 2'd2, 12'hABC, 0);
        chk("R3 open", bank_open_o, 4'b0100);
        chk("R3 row", rows_o[24 +: 12], 12'hABC);
        chk("R12 cmd", {cmd_vld_o, cmd_o}, {1'b1, C_ACT});
    endtask

    task automatic t_write_mask();
        do_reset();
        issue(1'b1, 1'b0, C_ACT, 2'd1, 12'h011, 0);
        issue(1'b1, 1'b0, C_WR, 2'd1, 12'h05A, 4'b0011);
        chk("R4 col", col_o, 10'h05A);
        chk("R4 ap/bank", {auto_pre_o, rw_bank_o}, 3'b001);
        chk("R4 burst", {burst_active_o, burst_wr_o, burst_cnt_o}, 4'b1100);
        chk("R7 beat0", wr_mask_o, 4'b0011);
        nop(4'b1100);
        chk("R7 beat1", wr_mask_o, 4'b1100);
        chk("R4 cnt1", burst_cnt_o, 1);
        nop(4'b0000);
        chk("R4 cnt2", burst_cnt_o, 2);
        nop(4'b1111);
        chk("R7 beat3", wr_mask_o, 4'b1111);
        chk("R4 cnt3", {burst_active_o, burst_cnt_o}, 3'b111);
        nop(4'b1111);
        chk("R7 no beat", wr_mask_o, 0);
        chk("R4 ended", burst_active_o, 0);
        chk("R5 no ap keeps open", bank_open_o, 4'b0010);
    endtask

    task automatic t_read_ap();
        do_reset();
        issue(1'b1, 1'b0, C_ACT, 2'd3, 12'h0F0, 0);
        issue(1'b1, 1'b0, C_RD, 2'd3, 12'h7FF, 4'b0101);
        chk("R4 rd fields", {auto_pre_o, col_o}, {1'b1, 10'h3FF});
        chk("R8 not yet", rd_hiz_o, 0);
        nop(0);
        chk("R8 two clocks", rd_hiz_o, 4'b0101);
        nop(0);
        chk("R8 one shot", rd_hiz_o, 0);
        nop(0);
        chk("R5 open before end", bank_open_o, 4'b1000);
        nop(0);
        chk("R5 ap closes", {burst_active_o, bank_open_o}, 5'b0);
    endtask

    task automatic t_bst();
        do_reset();
        issue(1'b1, 1'b0, C_ACT, 2'd0, 12'h001, 0);
        issue(1'b1, 1'b0, C_RD, 2'd0, 12'h400, 0);
        issue(1'b1, 1'b0, C_BST, 2'd0, 12'h000, 0);
        chk("R5 terminate", burst_active_o, 0);
        chk("R5 terminate keeps open", bank_open_o, 4'b0001);
    endtask

    task automatic t_precharge();
        do_reset();
        issue(1'b1, 1'b0, C_ACT, 2'd0, 12'h001, 0);
        issue(1'b1, 1'b0, C_ACT, 2'd1, 12'h002, 0);
        issue(1'b1, 1'b0, C_ACT, 2'd2, 12'h003, 0);
        issue(1'b1, 1'b0, C_PRE, 2'd1, 12'h000, 0);
        chk("R6 single", bank_open_o, 4'b0101);
        issue(1'b1, 1'b0, C_PRE, 2'd3, 12'h400, 0);
        chk("R6 all", bank_open_o, 0);
    endtask

    task automatic t_errors();
        do_reset();
        issue(1'b1, 1'b0, C_RD, 2'd0, 12'h000, 0);
        chk("R9 read idle", {err_o, burst_active_o}, 2'b10);
        nop(0);
        chk("R9 pulse", err_o, 0);
        issue(1'b1, 1'b0, C_ACT, 2'd0, 12'h001, 0);
        issue(1'b1, 1'b0, C_ACT, 2'd0, 12'h002, 0);
        chk("R9 double act", err_o, 1);
        chk("R9 row kept", rows_o[11:0], 12'h001);
    endtask

    task automatic t_power();
        do_reset();
        issue(1'b0, 1'b0, C_NOP, 2'd0, 12'h000, 0);
        chk("R10 pre pd", pwr_state_o, 1);
        nop(0);
        chk("R10 run", pwr_state_o, 0);
        issue(1'b1, 1'b0, C_ACT, 2'd0, 12'h001, 0);
        issue(1'b0, 1'b0, C_ACT, 2'd1, 12'h002, 0);
        chk("R10 act pd", pwr_state_o, 2);
        chk("R10 cmd ignored", bank_open_o, 4'b0001);
    endtask

    task automatic t_suspend();
        do_reset();
        issue(1'b1, 1'b0, C_ACT, 2'd0, 12'h001, 0);
        issue(1'b1, 1'b0, C_RD, 2'd0, 12'h000, 0);
        nop(4'b1010);
        chk("R11 cnt1", burst_cnt_o, 1);
        issue(1'b0, 1'b0, C_NOP, 2'd0, 12'h000, 0);
        chk("R10 suspend", pwr_state_o, 3);
        chk("R11 held", {burst_cnt_o, rd_hiz_o}, {2'd1, 4'b0000});
        issue(1'b0, 1'b0, C_NOP, 2'd0, 12'h000, 0);
        chk("R11 still held", {burst_cnt_o, rd_hiz_o}, {2'd1, 4'b0000});
        nop(0);
        chk("R11 resume", {pwr_state_o, burst_cnt_o, rd_hiz_o}, {2'd0, 2'd2, 4'b1010});
    endtask

    task automatic t_mode();
        do_reset();
        issue(1'b1, 1'b0, C_LMR, 2'd0, 12'h233, 0);
        chk("R12 mode", mode_o, 12'h233);
        chk("R12 lmr code", {cmd_vld_o, cmd_o}, {1'b1, C_LMR});
        issue(1'b1, 1'b0, C_REF, 2'd0, 12'h000, 0);
        chk("R12 ref code", {cmd_vld_o, cmd_o}, {1'b1, C_REF});
    endtask

    initial begin
        t_reset();
        t_deselect();
        t_activate();
        t_write_mask();
        t_read_ap();
        t_bst();
        t_precharge();
        t_errors();
        t_power();
        t_suspend();
        t_mode();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule